// File: doc/BRIEF.md
# DMA Status and Interrupt Unit

This unit keeps the transmit and receive status of a DMA-based network interface and drives a single interrupt line. The transmit and receive DMA engines each report events as one-cycle pulses. On a transmit packet sent or a receive packet received, a per-direction 8-bit packet count goes up and a packet flag is set. On a transmit underrun or a receive overflow, a sticky error flag is set.

Software uses a 32-bit register port with word addresses. It acknowledges an event by writing a one to the event's bit. An error flag clears at once. A packet acknowledge lowers the packet count by one, and the packet flag drops only when the count reaches zero. This lets software take queued packets one at a time and still see the flag until the queue is empty. An 8-bit mask selects which status bits raise the interrupt.

The pending vector has the low nibble of the receive status in bits 7:4 and the low nibble of the transmit status in bits 3:0. It is ANDed with the mask, and the OR of the result is registered onto the interrupt output.

Top module: `dsi_status_irq`

## Requirements
- R1: After a synchronous active-high reset, both status words, both counts, the mask and the read data are zero, and the interrupt output is low.
- R2: The transmit status is read at word address 0. Bit 0 is packet-sent, bit 1 is underrun, bits 23:16 are the packet count, and all other bits read zero. Read data appears on the port one cycle after a read request and holds until the next read.
- R3: The receive status is read at word address 1. Bit 0 is packet-received, bit 2 is overflow, bits 23:16 are the packet count, and all other bits read zero.
- R4: A packet event pulse without an acknowledge in the same cycle raises that direction's count by one and sets its packet flag. A count of 255 stays at 255.
- R5: Writing a status word with bit 0 set, and no packet event in the same cycle, lowers that direction's count by one. A count of 0 stays at 0. The packet flag clears only if the resulting count is zero and otherwise keeps its value.
- R6: A packet event and a packet acknowledge in the same cycle leave the count unchanged and leave the packet flag set.
- R7: Writing one to the underrun bit (bit 1 at address 0) or to the overflow bit (bit 2 at address 1) clears that flag. A write of zero to these bits changes nothing. An error event in the same cycle as the clear wins, and the flag stays set.
- R8: An underrun or overflow pulse sets the matching sticky flag.
- R9: The mask is written and read at word address 2 in bits 7:0. The pending vector, read at word address 3, equals the mask ANDed with {receive status bits 3:0, transmit status bits 3:0}. Writes to address 3 are ignored.
- R10: The interrupt output equals the OR of the pending vector of the previous cycle. It follows any status or mask change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_sent_i | input | 1 | Transmit engine packet-sent pulse |
| tx_underrun_i | input | 1 | Transmit engine underrun pulse |
| rx_rcvd_i | input | 1 | Receive engine packet-received pulse |
| rx_overflow_i | input | 1 | Receive engine overflow pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions treat every event input as an independent single-cycle level that is sampled at each edge. They treat a write strobe as acting on exactly the one addressed word. The properties describe one direction's count and flags under each combination of event and acknowledge. This includes a simultaneous increment and decrement and acknowledges at the 0 and 255 limits, so they need no assumption about how events are spaced. The stimulus changes inputs only on the falling edge. It mixes directed runs that push the counts to both limits with a long pseudo-random phase, in which any event, write or read may land in any cycle, including collisions of events with acknowledges.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int NCHAN    = 2;
  localparam int NIB_W    = 4;
  localparam int CNT_LSB  = 16;
  localparam int PKT_BIT  = 0;
  localparam int TX_ERR_BIT = 1;
  localparam int RX_ERR_BIT = 2;
  localparam logic [ADDR_W-1:0] A_TX   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RX   = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] A_PEND = 2'd3;

  function automatic int err_bit(int chan);
    return (chan == 0) ? TX_ERR_BIT : RX_ERR_BIT;
  endfunction
endpackage

// File: rtl/dsi_chan_status.sv
module dsi_chan_status #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int CNT_LSB = 16,
  parameter int ERR_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_evt,
  input  logic              err_evt,
  input  logic              pkt_ack,
  input  logic              err_clr,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_o,
  output logic              err_o,
  output logic [DATA_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             flag_q, flag_n;
  logic             err_q, err_n;

  always_comb begin
    cnt_n  = cnt_q;
    flag_n = flag_q;
    unique case ({pkt_evt, pkt_ack})
      2'b10: begin
        cnt_n  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
        flag_n = 1'b1;
      end
      2'b01: begin
        cnt_n  = (cnt_q == '0) ? cnt_q : cnt_q - CNT_ONE;
        flag_n = (cnt_n == '0) ? 1'b0 : flag_q;
      end
      2'b11: begin
        cnt_n  = cnt_q;
        flag_n = 1'b1;
      end
      default: ;
    endcase
    err_n = err_evt ? 1'b1 : (err_clr ? 1'b0 : err_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
      err_q  <= err_n;
    end
  end

  always_comb begin
    word_o = '0;
    word_o[0] = flag_q;
    word_o[ERR_BIT] = err_q;
    word_o[CNT_LSB +: CNT_W] = cnt_q;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dsi_irq_comb.sv
module dsi_irq_comb #(
  parameter int NIB_W = 4,
  localparam int VEC_W = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] tx_nib,
  input  logic [NIB_W-1:0] rx_nib,
  input  logic [VEC_W-1:0] mask,
  output logic [VEC_W-1:0] pending_o,
  output logic             irq_o
);
  logic [VEC_W-1:0] raw;
  logic             irq_q;

  assign raw       = {rx_nib, tx_nib};
  assign pending_o = mask & raw;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pending_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dsi_status_irq.sv
module dsi_status_irq
  import dsi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_sent_i,
  input  logic              tx_underrun_i,
  input  logic              rx_rcvd_i,
  input  logic              rx_overflow_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int VEC_W = 2 * NIB_W;

  logic [NCHAN-1:0]  pkt_evt, err_evt;
  logic [CNT_W-1:0]  chan_cnt  [NCHAN];
  logic              chan_flag [NCHAN];
  logic              chan_err  [NCHAN];
  logic [DATA_W-1:0] chan_word [NCHAN];
  logic [VEC_W-1:0]  mask_q;
  logic [VEC_W-1:0]  pending;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_wdata;

  assign pkt_evt = {rx_rcvd_i, tx_sent_i};
  assign err_evt = {rx_overflow_i, tx_underrun_i};
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:VEC_W];

  for (genvar g = 0; g < NCHAN; g++) begin : g_chan
    localparam int EB = err_bit(g);
    logic sel;
    assign sel = bus_wr_i && (bus_addr_i == ADDR_W'(g));
    dsi_chan_status #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .CNT_LSB(CNT_LSB),
      .ERR_BIT(EB)
    ) u_chan (
      .clk    (clk),
      .rst    (rst),
      .pkt_evt(pkt_evt[g]),
      .err_evt(err_evt[g]),
      .pkt_ack(sel && bus_wdata_i[PKT_BIT]),
      .err_clr(sel && bus_wdata_i[EB]),
      .cnt_o  (chan_cnt[g]),
      .flag_o (chan_flag[g]),
      .err_o  (chan_err[g]),
      .word_o (chan_word[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                                    mask_q <= '0;
    else if (bus_wr_i && bus_addr_i == A_MASK)  mask_q <= bus_wdata_i[VEC_W-1:0];
  end

  dsi_irq_comb #(.NIB_W(NIB_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .tx_nib   (chan_word[0][NIB_W-1:0]),
    .rx_nib   (chan_word[1][NIB_W-1:0]),
    .mask     (mask_q),
    .pending_o(pending),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd_i) begin
      unique case (bus_addr_i)
        A_TX:    rdata_q <= chan_word[0];
        A_RX:    rdata_q <= chan_word[1];
        A_MASK:  rdata_q <= DATA_W'(mask_q);
        default: rdata_q <= DATA_W'(pending);
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/dsi_status_irq_chk.sv
module dsi_status_irq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_sent,
  input logic             tx_underrun,
  input logic             rx_rcvd,
  input logic             rx_overflow,
  input logic             wr,
  input logic [1:0]       addr,
  input logic [31:0]      wdata,
  input logic [CNT_W-1:0] tx_cnt,
  input logic             tx_flag,
  input logic             tx_err,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             rx_flag,
  input logic             rx_err,
  input logic [7:0]       mask,
  input logic             irq
);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic tx_ack, rx_ack, rx_ovf_clr;
  logic [7:0] raw;
  assign tx_ack     = wr && addr == 2'd0 && wdata[0];
  assign rx_ack     = wr && addr == 2'd1 && wdata[0];
  assign rx_ovf_clr = wr && addr == 2'd1 && wdata[2];
  assign raw = {1'b0, rx_err, 1'b0, rx_flag, 2'b00, tx_err, tx_flag};

  AST_TX_INC: assert property (@(posedge clk) disable iff (rst)
    (tx_sent && !tx_ack && tx_cnt != MAXC) |=> (tx_cnt == CNT_W'($past(tx_cnt) + 1'b1)) && tx_flag); // R4
  AST_TX_SAT: assert property (@(posedge clk) disable iff (rst)
    (tx_sent && !tx_ack && tx_cnt == MAXC) |=> tx_cnt == MAXC); // R4
  AST_RX_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (rx_ack && !rx_rcvd && rx_cnt == '0) |=> rx_cnt == '0 && !rx_flag); // R5
  AST_RX_KEEP: assert property (@(posedge clk) disable iff (rst)
    (rx_ack && !rx_rcvd && rx_cnt > CNT_W'(1) && rx_flag) |=> rx_flag); // R5
  AST_TX_BOTH: assert property (@(posedge clk) disable iff (rst)
    (tx_sent && tx_ack) |=> $stable(tx_cnt) && tx_flag); // R6
  AST_OVF_CLR: assert property (@(posedge clk) disable iff (rst)
    (rx_ovf_clr && !rx_overflow) |=> !rx_err); // R7
  AST_UR_SET: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> tx_err); // R8
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(mask & raw))); // R10
endmodule

bind dsi_status_irq dsi_status_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_sent    (tx_sent_i),
  .tx_underrun(tx_underrun_i),
  .rx_rcvd    (rx_rcvd_i),
  .rx_overflow(rx_overflow_i),
  .wr         (bus_wr_i),
  .addr       (bus_addr_i),
  .wdata      (bus_wdata_i),
  .tx_cnt     (chan_cnt[0]),
  .tx_flag    (chan_flag[0]),
  .tx_err     (chan_err[0]),
  .rx_cnt     (chan_cnt[1]),
  .rx_flag    (chan_flag[1]),
  .rx_err     (chan_err[1]),
  .mask       (mask_q),
  .irq        (irq_o)
);

// File: tb/dsi_status_irq_bench.sv
module dsi_status_irq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic ts = 0, tu = 0, rr = 0, ro = 0, wr = 0, rd = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;

  dsi_status_irq u_dsi_status_irq (
    .clk(clk), .rst(rst), .tx_sent_i(ts), .tx_underrun_i(tu),
    .rx_rcvd_i(rr), .rx_overflow_i(ro), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";

  int m_cnt[2], m_flag[2], m_err[2];
  int m_mask = 0, m_irq = 0, m_rd = 0, m_rdchk = 0, live = 0;

  function automatic int m_word(int c);
    return (m_cnt[c] << 16) | (m_err[c] << ((c == 0) ? 1 : 2)) | m_flag[c];
  endfunction
  function automatic int m_pend();
    return m_mask & (((m_word(1) & 15) << 4) | (m_word(0) & 15));
  endfunction
  function automatic int m_reg(int a);
    case (a)
      0: return m_word(0);
      1: return m_word(1);
      2: return m_mask;
      default: return m_pend();
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin m_cnt[c] = 0; m_flag[c] = 0; m_err[c] = 0; end
      m_mask = 0; m_irq = 0; m_rd = 0; m_rdchk = 0; live = 0;
    end else begin
      int pe, ee, ack, clr;
      live = 1;
      if (rd) m_rd = m_reg(int'(addr));
      m_rdchk = rd;
      m_irq = (m_pend() != 0);
      for (int c = 0; c < 2; c++) begin
        pe  = (c == 0) ? ts : rr;
        ee  = (c == 0) ? tu : ro;
        ack = wr && addr == c && wdata[0];
        clr = wr && addr == c && wdata[(c == 0) ? 1 : 2];
        if (pe && ack) m_flag[c] = 1;
        else if (pe) begin
          if (m_cnt[c] < 255) m_cnt[c]++;
          m_flag[c] = 1;
        end else if (ack) begin
          if (m_cnt[c] > 0) m_cnt[c]--;
          if (m_cnt[c] == 0) m_flag[c] = 0;
        end
        if (ee) m_err[c] = 1;
        else if (clr) m_err[c] = 0;
      end
      if (wr && addr == 2) m_mask = wdata & 255;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: %s got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      check("R10", "irq", int'(irq), m_irq);
      if (m_rdchk) check(cur_req, "rdata", int'(rdata), m_rd);
    end else if (!rst) begin
      check("R1", "irq after reset", int'(irq), 0);
    end
  end

  task automatic step(bit s_ts, bit s_tu, bit s_rr, bit s_ro,
                      bit s_wr, bit s_rd, int s_a, int s_wd);
    @(negedge clk);
    ts = s_ts; tu = s_tu; rr = s_rr; ro = s_ro;
    wr = s_wr; rd = s_rd; addr = 2'(s_a); wdata = 32'(s_wd);
  endtask
  task automatic rd_reg(int a); step(0,0,0,0, 0,1, a, 0); endtask
  task automatic wr_reg(int a, int d); step(0,0,0,0, 1,0, a, d); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    for (int a = 0; a < 4; a++) rd_reg(a);
    step(0,0,0,0, 0,0, 0,0);
    check("R1", "rdata reset", int'(rdata), 0);

    cur_req = "R4";
    repeat (3) step(1,0,0,0, 0,0, 0,0);
    rd_reg(0);
    repeat (260) step(0,0,1,0, 0,0, 0,0);
    rd_reg(1);
    step(0,0,0,0, 0,0, 0,0);
    check("R4", "rx count saturated", int'(rdata[23:16]), 255);

    cur_req = "R8";
    step(0,1,0,1, 0,0, 0,0);
    rd_reg(0); rd_reg(1);

    cur_req = "R5";
    wr_reg(1, 1); rd_reg(1);
    wr_reg(0, 1); rd_reg(0); wr_reg(0, 1); rd_reg(0);
    wr_reg(0, 1); rd_reg(0); wr_reg(0, 1); rd_reg(0);
    step(0,0,0,0, 0,0, 0,0);
    check("R5", "tx word at floor", int'(rdata), 32'h2);

    cur_req = "R6";
    step(1,0,0,0, 1,0, 0,1); rd_reg(0);
    step(1,0,0,0, 0,0, 0,0); step(1,0,0,0, 1,0, 0,1); rd_reg(0);

    cur_req = "R7";
    wr_reg(0, 0); rd_reg(0);
    step(0,1,0,0, 1,0, 0,2); rd_reg(0);
    wr_reg(0, 2); rd_reg(0);
    wr_reg(1, 4); rd_reg(1);

    cur_req = "R9";
    wr_reg(2, 32'hFF); rd_reg(2); rd_reg(3);
    wr_reg(3, 32'h0); rd_reg(3);
    wr_reg(2, 32'h10); rd_reg(3);
    step(0,0,0,1, 0,0, 0,0); wr_reg(2, 32'h40); rd_reg(3);

    for (int i = 0; i < 4000; i++) begin
      int a = $urandom % 4;
      bit w = ($urandom % 3) == 0;
      cur_req = (a == 0) ? "R2" : (a == 1) ? "R3" : "R9";
      step(($urandom % 3) == 0, ($urandom % 16) == 0, ($urandom % 3) == 0,
           ($urandom % 16) == 0, w, !w, a, int'($urandom));
    end
    step(0,0,0,0, 0,0, 0,0);
    step(0,0,0,0, 0,0, 0,0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run got hung expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule